// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the message-signalled interrupt capability structure of one PCI function. It sits in that function's configuration space, behind a dword-addressed, byte-enabled configuration access port. Software programs the message address, the message data, the number of vectors it grants and, when present, a per-vector mask. An interrupt dispatcher next to the block reads those settings from dedicated output ports and reports vectors it could not send because they were masked.

Two parameters fix the layout. One chooses between a 32-bit and a 64-bit message address. The other adds or removes the per-vector mask and pending registers. A third parameter gives the capable vector count as a base-2 logarithm. Every field has its own write mask.

On each write that touches the structure while MSI is enabled, the block does three things:
- It reduces an over-large vector grant to the capable value.
- It drops pending bits that lie at or above the granted count.
- It raises a one-cycle request to withdraw the function's legacy INTx interrupt.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset the enable bit, the granted-vector field, both address registers, the data, the mask and the pending registers read zero. The control dword (capability base, bytes 2..3) reads the fixed capability bits from parameters: bit 16 enable, bits 19:17 capable log2 count, bits 22:20 granted log2 count, bit 23 64-bit address, bit 24 per-vector masking. All other bits read zero.
- R2: In the control dword only bit 16 and bits 22:20 are writable. All other control bits keep their parameter or zero values whatever is written.
- R3: The low address register (base+1 dword) always reads bits 1:0 as zero. Bits 31:2 are writable.
- R4: With 64-bit addressing, the high address register at base+2 is fully writable. `msi_addr` is {high, low}; without 64-bit addressing the upper half is zero.
- R5: The message data register is 16 bits wide. It sits in the low half of base+3 (64-bit) or base+2 (32-bit). The upper half of that dword reads zero.
- R6: With masking, the mask dword follows the data dword. Only mask bits below the capable vector count are writable; the others read zero.
- R7: On a write that hits the structure and leaves enable set, a granted field above the capable value is stored as the capable value. While disabled, the written granted value is stored as is.
- R8: `intx_deassert` is high for exactly the cycle after a write that hits the structure and leaves MSI enabled. It stays low after any other write.
- R9: A write is ignored if none of its enabled bytes lies inside the structure, whose length is 10, 14, 20 or 24 bytes depending on the options. Such a dword reads zero.
- R10: The pending dword follows the mask dword. `pend_set` sets pending bits and `pend_clr` clears them, limited to capable vectors. Software writes to pending are ignored. A write that hits the structure with enable set clears pending bits at or above the granted count.
- R11: Each byte lane of a write changes only when its byte enable is set.
- R12: `msi_en`, `msi_mme`, `msi_addr`, `msi_data`, `msi_mask` and `msi_pend` always equal the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw_addr`, combinational |
| pend_set | input | 32 | Dispatcher: set pending bits |
| pend_clr | input | 32 | Dispatcher: clear pending bits |
| msi_en | output | 1 | MSI enabled |
| msi_mme | output | 3 | Granted vector count, log2 |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | 32 | Per-vector mask |
| msi_pend | output | 32 | Pending vectors |
| intx_deassert | output | 1 | One-cycle request to withdraw INTx |

## Verification
The bench sweeps every granted-vector value with enable set. A design without the clamp would grant eight or more vectors to a four-vector function. A design that clamps while disabled would lose the stored value. Every byte-enable pattern is tried on the low address register, which catches a lost lane mask or writable alignment bits. Writes just past the end of the structure are checked in both layouts, including the half-covered data dword of the smallest layout, because an off-by-one in the length would corrupt an adjacent capability. Pending bits are checked for trimming when the grant shrinks under enable, and for immunity to software writes.

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter bit         ADDR64   = 1'b1,
  parameter bit         PVM      = 1'b1,
  parameter int         LOG2_CAP = 2,
  parameter logic [5:0] BASE_DW  = 6'h14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_dw_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] pend_set,
  input  logic [31:0] pend_clr,
  output logic        msi_en,
  output logic [2:0]  msi_mme,
  output logic [63:0] msi_addr,
  output logic [15:0] msi_data,
  output logic [31:0] msi_mask,
  output logic [31:0] msi_pend,
  output logic        intx_deassert
);

  localparam int          SIZE     = ADDR64 ? (PVM ? 24 : 14) : (PVM ? 20 : 10);
  localparam int          NCAP     = 1 << LOG2_CAP;
  localparam logic [31:0] CAP_MASK = 32'hFFFF_FFFF >> (32 - NCAP);
  localparam logic [2:0]  CAP_LOG  = 3'(LOG2_CAP);
  localparam logic [5:0]  D_ALO    = BASE_DW + 6'd1;
  localparam logic [5:0]  D_AHI    = BASE_DW + 6'd2;
  localparam logic [5:0]  D_DAT    = BASE_DW + (ADDR64 ? 6'd3 : 6'd2);
  localparam logic [5:0]  D_MSK    = D_DAT + 6'd1;
  localparam logic [5:0]  D_PND    = D_DAT + 6'd2;
  localparam logic [31:0] WM_ALO   = 32'hFFFF_FFFC;
  localparam logic [31:0] WM_AHI   = ADDR64 ? 32'hFFFF_FFFF : 32'h0;
  localparam logic [31:0] WM_MSK   = PVM ? CAP_MASK : 32'h0;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be, input logic [31:0] wm);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[8*i +: 8] = (nw[8*i +: 8] & wm[8*i +: 8]) | (old[8*i +: 8] & ~wm[8*i +: 8]);
    return r;
  endfunction

  logic        en_q, intx_q;
  logic [2:0]  mme_q;
  logic [31:0] alo_q, ahi_q, msk_q, pnd_q;
  logic [15:0] dat_q;

  logic        hit, wr_hit, en_n;
  logic [2:0]  mme_n;
  logic [31:0] pnd_n, gnt_mask, dat_w;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int rel;
      rel = int'({cfg_dw_addr, 2'b00}) + i - int'({BASE_DW, 2'b00});
      if (cfg_be[i] && rel >= 0 && rel < SIZE) hit = 1'b1;
    end
  end

  assign wr_hit = cfg_wr && hit;

  always_comb begin
    en_n  = en_q;
    mme_n = mme_q;
    if (cfg_wr && cfg_dw_addr == BASE_DW && cfg_be[2]) begin
      en_n  = cfg_wdata[16];
      mme_n = cfg_wdata[22:20];
    end
    if (wr_hit && en_n && mme_n > CAP_LOG) mme_n = CAP_LOG;
    gnt_mask = ~(32'hFFFF_FFFF << (8'd1 << mme_n));
    pnd_n = PVM ? ((pnd_q | pend_set) & ~pend_clr & CAP_MASK) : 32'h0;
    if (wr_hit && en_n) pnd_n = pnd_n & gnt_mask;
  end

  assign dat_w = merge({16'h0, dat_q}, cfg_wdata, cfg_be, 32'h0000_FFFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mme_q <= 3'd0; intx_q <= 1'b0;
      alo_q <= '0; ahi_q <= '0; dat_q <= '0; msk_q <= '0; pnd_q <= '0;
    end else begin
      en_q   <= en_n;
      mme_q  <= mme_n;
      intx_q <= wr_hit && en_n;
      pnd_q  <= pnd_n;
      if (cfg_wr && cfg_dw_addr == D_ALO) alo_q <= merge(alo_q, cfg_wdata, cfg_be, WM_ALO);
      if (cfg_wr && cfg_dw_addr == D_AHI) ahi_q <= merge(ahi_q, cfg_wdata, cfg_be, WM_AHI);
      if (cfg_wr && cfg_dw_addr == D_DAT) dat_q <= dat_w[15:0];
      if (cfg_wr && cfg_dw_addr == D_MSK) msk_q <= merge(msk_q, cfg_wdata, cfg_be, WM_MSK);
    end
  end

  always_comb begin
    cfg_rdata = 32'h0;
    if (cfg_dw_addr == BASE_DW)
      cfg_rdata = {7'h0, PVM, ADDR64, mme_q, CAP_LOG, en_q, 16'h0};
    else if (cfg_dw_addr == D_ALO)            cfg_rdata = alo_q;
    else if (ADDR64 && cfg_dw_addr == D_AHI)  cfg_rdata = ahi_q;
    else if (cfg_dw_addr == D_DAT)            cfg_rdata = {16'h0, dat_q};
    else if (PVM && cfg_dw_addr == D_MSK)     cfg_rdata = msk_q;
    else if (PVM && cfg_dw_addr == D_PND)     cfg_rdata = pnd_q;
  end

  assign msi_en        = en_q;
  assign msi_mme       = mme_q;
  assign msi_addr      = {ADDR64 ? ahi_q : 32'h0, alo_q};
  assign msi_data      = dat_q;
  assign msi_mask      = msk_q;
  assign msi_pend      = pnd_q;
  assign intx_deassert = intx_q;

  p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_addr[1:0] == 2'b00);

  p_mask_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_mask & ~WM_MSK) == 32'h0);

  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> msi_mme <= CAP_LOG);

  p_intx_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> msi_en);

  p_ignore_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !hit) |=> $stable({en_q, mme_q, alo_q, ahi_q, dat_q, msk_q}) && !intx_deassert);

  p_pend_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_pend & ~CAP_MASK) == 32'h0);

endmodule

// File: tb/msi_cap_regs_tb.sv
`timescale 1ns/1ps
module msi_cap_regs_tb_top;
  localparam logic [5:0] B = 6'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_a = 1'b0, wr_b = 1'b0;
  logic [5:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wd = '0, pset = '0, pclr = '0;
  logic [31:0] rd_a, rd_b, mask_a, pend_a, mask_b, pend_b;
  logic en_a, en_b, intx_a, intx_b, last_intx;
  logic [2:0] mme_a, mme_b;
  logic [63:0] ad_a, ad_b;
  logic [15:0] da_a, da_b;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  msi_cap_regs #(.ADDR64(1'b1), .PVM(1'b1), .LOG2_CAP(2), .BASE_DW(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr_a), .cfg_dw_addr(addr), .cfg_be(be),
    .cfg_wdata(wd), .cfg_rdata(rd_a), .pend_set(pset), .pend_clr(pclr),
    .msi_en(en_a), .msi_mme(mme_a), .msi_addr(ad_a), .msi_data(da_a),
    .msi_mask(mask_a), .msi_pend(pend_a), .intx_deassert(intx_a));

  msi_cap_regs #(.ADDR64(1'b0), .PVM(1'b0), .LOG2_CAP(0), .BASE_DW(B)) dut32_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr_b), .cfg_dw_addr(addr), .cfg_be(be),
    .cfg_wdata(wd), .cfg_rdata(rd_b), .pend_set(32'h0), .pend_clr(32'h0),
    .msi_en(en_b), .msi_mme(mme_b), .msi_addr(ad_b), .msi_data(da_b),
    .msi_mask(mask_b), .msi_pend(pend_b), .intx_deassert(intx_b));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input bit sel_b, input logic [5:0] a, input logic [3:0] e, input logic [31:0] d);
    @(negedge clk);
    wr_a = !sel_b; wr_b = sel_b; addr = a; be = e; wd = d;
    @(negedge clk);
    last_intx = sel_b ? intx_b : intx_a;
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic rd(input bit sel_b, input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = sel_b ? rd_b : rd_a;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(0, B, v);  chk("R1 ctrl A", v, 32'h0184_0000);
    rd(1, B, v);  chk("R1 ctrl B", v, 32'h0);
    for (int k = 1; k < 6; k++) begin
      rd(0, B + 6'(k), v); chk("R1 regs zero", v, 32'h0);
    end
    chk("R1 R12 outputs", {en_a, mme_a, ad_a, da_a, mask_a, pend_a, intx_a}, '0);

    // R2 R7: all ones with enable clear, granted value stored unclamped
    wr(0, B, 4'hF, 32'hFFFE_FFFF);
    rd(0, B, v);  chk("R2 R7 ctrl mask, no clamp when disabled", v, 32'h01F4_0000);
    chk("R8 no intx when disabled", last_intx, 1'b0);

    // R7 R8: sweep granted field with enable set
    for (int m = 0; m < 8; m++) begin
      wr(0, B, 4'b0100, {9'h0, 3'(m), 3'b000, 1'b1, 16'h0});
      ex = (m > 2) ? 32'd2 : 32'(m);
      chk("R8 intx pulse on enabled write", last_intx, 1'b1);
      chk("R7 clamp", {29'h0, mme_a}, ex);
      rd(0, B, v); chk("R7 R12 ctrl readback", v, 32'h0185_0000 | (ex << 20));
      chk("R8 intx single cycle", intx_a, 1'b0);
    end
    wr(0, B, 4'b0100, 32'h0);
    chk("R8 no intx after disable", last_intx, 1'b0);

    // R3 R11: byte-enable sweep on low address
    for (int e = 0; e < 16; e++) begin
      wr(0, B + 6'd1, 4'hF, 32'h0);
      wr(0, B + 6'd1, 4'(e), 32'hFFFF_FFFF);
      ex = 32'h0;
      for (int i = 0; i < 4; i++) if (e[i]) ex = ex | (32'hFF << (8 * i));
      ex = ex & 32'hFFFF_FFFC;
      rd(0, B + 6'd1, v); chk("R3 R11 addr low lanes", v, ex);
    end

    // R4 R12
    wr(0, B + 6'd2, 4'hF, 32'hDEAD_BEEF);
    rd(0, B + 6'd2, v); chk("R4 addr high", v, 32'hDEAD_BEEF);
    chk("R4 R12 msi_addr", ad_a, 64'hDEAD_BEEF_FFFF_FFFC);

    // R5
    wr(0, B + 6'd3, 4'hF, 32'hFFFF_5A5A);
    rd(0, B + 6'd3, v); chk("R5 data", v, 32'h0000_5A5A);
    chk("R5 R12 msi_data", {48'h0, da_a}, 64'h5A5A);

    // R6
    wr(0, B + 6'd4, 4'hF, 32'hFFFF_FFFF);
    rd(0, B + 6'd4, v); chk("R6 mask capable bits only", v, 32'h0000_000F);
    wr(0, B + 6'd4, 4'hF, 32'h0);

    // R10: pending
    @(negedge clk); pset = 32'hFFFF_FFFF;
    @(negedge clk); pset = 32'h0;
    rd(0, B + 6'd5, v); chk("R10 pend set limited", v, 32'hF);
    wr(0, B + 6'd5, 4'hF, 32'h0);
    rd(0, B + 6'd5, v); chk("R10 software write ignored", v, 32'hF);
    wr(0, B, 4'b0100, 32'h0011_0000);
    chk("R10 pend trimmed to grant", pend_a, 64'h3);
    @(negedge clk); pclr = 32'h1;
    @(negedge clk); pclr = 32'h0;
    chk("R10 pend clear", pend_a, 64'h2);

    // R9: writes outside the structure
    wr(0, B + 6'd6, 4'hF, 32'hFFFF_FFFF);
    chk("R9 no intx on miss", last_intx, 1'b0);
    wr(0, B - 6'd1, 4'hF, 32'hFFFF_FFFF);
    rd(0, B + 6'd6, v); chk("R9 outside reads zero", v, 32'h0);
    rd(0, B, v);  chk("R9 ctrl unchanged", v, 32'h0195_0000);
    chk("R9 regs unchanged", {ad_a, da_a, mask_a, pend_a}, {64'hDEAD_BEEF_FFFF_FFFC, 16'h5A5A, 32'h0, 32'h2});

    // R5 R9 small layout: data dword half outside
    wr(1, B + 6'd2, 4'hF, 32'hABCD_1234);
    rd(1, B + 6'd2, v); chk("R5 small layout data", v, 32'h0000_1234);
    wr(1, B + 6'd3, 4'hF, 32'hFFFF_FFFF);
    rd(1, B + 6'd3, v); chk("R9 small layout past end", v, 32'h0);
    chk("R4 R6 small layout outputs", {ad_b[63:32], mask_b, pend_b}, 96'h0);

    finish_run();
  end
endmodule